// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Counter

This block keeps a free-running microsecond count for software timing loops. A fast peripheral clock drives a fractional prescaler. The prescaler adds a programmable step on every clock. Each time the running sum reaches a programmable limit, it emits one tick, and each tick advances an up-counter. The counter wraps on overflow and raises no interrupt. With the reset configuration and a 12 MHz clock, the counter advances once per microsecond, so no setup is needed after reset.

Software works with three 32-bit registers on a simple bus. Writes take effect in one cycle, and read data is combinational from the address:

- The count register can only be read.
- The configuration register holds the step and limit fields.
- The hold register stops both the prescaler and the counter without losing the partial fraction already accumulated.

Top module: `usec_timer`

## Requirements
- R1: The count register at offset 0x00 is COUNT_W bits wide (32 by default), zero-extended to 32 bits on read. It counts up and wraps from its all-ones value to 0.
- R2: After reset the count reads 0, the configuration reads 0x0000000B and the hold register reads 0. The counter then advances with no register write: one step per 12 clocks.
- R3: The configuration register at offset 0x04 holds the limit field in bits [7:0] and the step field in bits [15:8]. Bits [31:16] read as 0 whatever was written.
- R4: When step is at most limit, the count after n running clocks since the last configuration write equals the count at the write plus floor(n*(step+1)/(limit+1)). The accumulator always stays below limit+1.
- R5: When step is greater than or equal to limit, the count advances on every running clock.
- R6: A configuration write clears the accumulator, and the count does not advance on the clock of that write. The first tick after the write comes after ceil((limit+1)/(step+1)) running clocks.
- R7: Writing 1 to bit 0 of the hold register at offset 0x3C stops the counter and the prescaler from the next clock on. Writing 0 resumes them with the accumulated remainder intact. Bit 0 reads back the hold state, and the other bits read 0.
- R8: Writes to the count register have no effect on the count.
- R9: Reads of any other offset return 0, and writes to any other offset change no register.
- R10: The count changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench goes after the fractional remainder in several ways. It uses a ratio of 3/7, where a design that dropped the remainder would fall behind. It uses a 1/100 ratio, where an off-by-one in the limit would tick a cycle early or late. It pauses a count in mid-fraction, where a design that cleared or kept stepping the accumulator during the pause would tick at the wrong cycle after resuming.

It rewrites the configuration just before a tick is due, which catches a design that keeps the old remainder or ticks on the write cycle. A step larger than the limit catches a design whose accumulator runs away. A narrow instance catches a count that saturates instead of wrapping. Writes to the count register and to unmapped offsets catch stray decoding.

// File: rtl/usec_pkg.sv
package usec_pkg;

    localparam int DATA_W  = 32;
    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 6;
    localparam int ACC_W   = FIELD_W + 2;

    localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_RATIO  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_HOLD   = 6'h3C;

    // step field sits above the limit field
    typedef struct packed {
        logic [FIELD_W-1:0] step;
        logic [FIELD_W-1:0] limit;
    } ratio_t;

    localparam ratio_t RATIO_RESET = '{step: 8'h00, limit: 8'h0B};

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RATIO,
        SEL_HOLD
    } sel_e;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_COUNT: return SEL_COUNT;
            OFF_RATIO: return SEL_RATIO;
            OFF_HOLD:  return SEL_HOLD;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [ACC_W-1:0] widen_plus_one(input logic [FIELD_W-1:0] v);
        return ACC_W'(v) + ACC_W'(1);
    endfunction

endpackage

// File: rtl/usec_regs.sv
module usec_regs
    import usec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_ext,
    output ratio_t            ratio_q,
    output logic              hold_q,
    output logic              ratio_load,
    output logic [DATA_W-1:0] rdata
);

    sel_e sel;

    assign sel        = decode_addr(addr);
    assign ratio_load = wr_en && (sel == SEL_RATIO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= RATIO_RESET;
            hold_q  <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_RATIO) ratio_q <= ratio_t'(wdata[2*FIELD_W-1:0]);
            if (sel == SEL_HOLD)  hold_q  <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_COUNT: rdata = count_ext;
            SEL_RATIO: rdata = DATA_W'(ratio_q);
            SEL_HOLD:  rdata = DATA_W'(hold_q);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/usec_prescaler.sv
module usec_prescaler
    import usec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  ratio_t           ratio,
    output logic             tick,
    output logic [ACC_W-1:0] acc_q
);

    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] lim;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] rem;
    logic             reach;
    logic [ACC_W-1:0] acc_d;

    assign inc   = widen_plus_one(ratio.step);
    assign lim   = widen_plus_one(ratio.limit);
    assign sum   = acc_q + inc;
    assign reach = (sum >= lim);
    assign rem   = sum - lim;
    assign tick  = run && !clear && reach;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (run) begin
            if (!reach)          acc_d = sum;
            else if (rem >= lim) acc_d = '0;   // step exceeds limit: one tick per clock
            else                 acc_d = rem;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

endmodule

// File: rtl/usec_count.sv
module usec_count #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    output logic [COUNT_W-1:0] count_q
);

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (step) count_q <= count_q + COUNT_W'(1);
    end

endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    ratio_t             ratio_q;
    logic               hold_q;
    logic               ratio_load;
    logic               tick;
    logic [ACC_W-1:0]   acc_q;
    logic [COUNT_W-1:0] count_q;
    logic [DATA_W-1:0]  count_ext;

    assign count_ext = DATA_W'(count_q);

    usec_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .count_ext  (count_ext),
        .ratio_q    (ratio_q),
        .hold_q     (hold_q),
        .ratio_load (ratio_load),
        .rdata      (bus_rdata)
    );

    usec_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (!hold_q),
        .clear (ratio_load),
        .ratio (ratio_q),
        .tick  (tick),
        .acc_q (acc_q)
    );

    usec_count #(.COUNT_W(COUNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (tick),
        .count_q (count_q)
    );

endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk
    import usec_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [COUNT_W-1:0] count_q,
    input logic               hold_q,
    input logic               ratio_load,
    input ratio_t             ratio_q,
    input logic [ACC_W-1:0]   acc_q
);

    assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_q) |-> count_q == COUNT_W'($past(count_q) + COUNT_W'(1)));

    assert_hold_count_R7: assert property (@(posedge clk) disable iff (rst)
        $past(hold_q) |-> $stable(count_q));

    assert_hold_acc_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(hold_q) && !$past(ratio_load)) |-> $stable(acc_q));

    assert_load_clears_R6: assert property (@(posedge clk) disable iff (rst)
        $past(ratio_load) |-> (acc_q == '0 && $stable(count_q)));

    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        acc_q <= ACC_W'(ratio_q.limit));

endmodule

bind usec_timer usec_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count_q    (count_q),
    .hold_q     (hold_q),
    .ratio_load (ratio_load),
    .ratio_q    (ratio_q),
    .acc_q      (acc_q)
);

// File: tb/usec_timer_tb.sv
module usec_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wr_n = 1'b0;
    logic [5:0]  addr_n = '0;
    logic [31:0] wdata_n = '0;
    logic [31:0] rdata_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    usec_timer u_dut (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata)
    );

    usec_timer #(.COUNT_W(8)) u_dut_w (
        .clk(clk), .rst(rst), .bus_wr(wr_n), .bus_addr(addr_n),
        .bus_wdata(wdata_n), .bus_rdata(rdata_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic test_reset;
        logic [31:0] v;
        rd_reg(6'h00, v); check("R2 count after reset", v, 32'h0);
        rd_reg(6'h04, v); check("R2 config after reset", v, 32'h0000000B);
        rd_reg(6'h3C, v); check("R2 hold after reset", v, 32'h0);
        idle(24);
        rd_reg(6'h00, v); check("R2 free run 24 clocks", v, 32'd2);
    endtask

    task automatic test_fields;
        logic [31:0] v;
        wr_reg(6'h04, 32'h0000_0206);
        rd_reg(6'h04, v); check("R3 config readback", v, 32'h0000_0206);
        wr_reg(6'h04, 32'hABCD_1234);
        rd_reg(6'h04, v); check("R3 upper bits read zero", v, 32'h0000_1234);
    endtask

    task automatic test_fraction;
        logic [31:0] c, v;
        wr_reg(6'h04, 32'h0000_0206);   // step 2, limit 6: 3/7
        rd_reg(6'h00, c);
        idle(10);
        rd_reg(6'h00, v); check("R4 3/7 after 10", v, c + 32'd4);
        idle(25);
        rd_reg(6'h00, v); check("R4 3/7 after 35", v, c + 32'd15);
    endtask

    task automatic test_slow;
        logic [31:0] c, v;
        wr_reg(6'h04, 32'h0000_0063);   // 1/100
        rd_reg(6'h00, c);
        idle(99);
        rd_reg(6'h00, v); check("R6 no tick before limit+1", v, c);
        idle(1);
        rd_reg(6'h00, v); check("R6 first tick at limit+1", v, c + 32'd1);
        idle(150);
        rd_reg(6'h00, v); check("R4 1/100 after 250", v, c + 32'd2);
    endtask

    task automatic test_clear;
        logic [31:0] c, v;
        wr_reg(6'h04, 32'h0000_000B);
        rd_reg(6'h00, c);
        idle(11);
        wr_reg(6'h04, 32'h0000_000B);   // rewrite just before the tick
        rd_reg(6'h00, v); check("R6 no tick on write clock", v, c);
        idle(11);
        rd_reg(6'h00, v); check("R6 remainder cleared", v, c);
        idle(1);
        rd_reg(6'h00, v); check("R6 tick 12 after rewrite", v, c + 32'd1);
    endtask

    task automatic test_fast;
        logic [31:0] c, v;
        wr_reg(6'h04, 32'h0000_0503);   // step above limit
        rd_reg(6'h00, c);
        idle(20);
        rd_reg(6'h00, v); check("R5 step>limit every clock", v, c + 32'd20);
        wr_reg(6'h04, 32'h0000_0000);
        rd_reg(6'h00, c);
        idle(7);
        rd_reg(6'h00, v); check("R5 step==limit every clock", v, c + 32'd7);
    endtask

    task automatic test_hold;
        logic [31:0] c, v;
        wr_reg(6'h04, 32'h0000_000B);
        rd_reg(6'h00, c);
        idle(4);
        wr_reg(6'h3C, 32'h1);           // this clock still runs: remainder 5
        idle(30);
        rd_reg(6'h00, v); check("R7 count held", v, c);
        rd_reg(6'h3C, v); check("R7 hold readback", v, 32'h1);
        wr_reg(6'h00, 32'hDEAD_BEEF);
        rd_reg(6'h00, v); check("R8 count write ignored", v, c);
        wr_reg(6'h3C, 32'h0);           // still held on this clock
        idle(6);
        rd_reg(6'h00, v); check("R7 remainder kept, no early tick", v, c);
        idle(1);
        rd_reg(6'h00, v); check("R7 tick after resume", v, c + 32'd1);
        rd_reg(6'h3C, v); check("R7 hold cleared", v, 32'h0);
    endtask

    task automatic test_unmapped;
        logic [31:0] v;
        wr_reg(6'h08, 32'hFFFF_FFFF);
        rd_reg(6'h08, v); check("R9 unmapped reads zero", v, 32'h0);
        rd_reg(6'h04, v); check("R9 config untouched", v, 32'h0000_000B);
        rd_reg(6'h3C, v); check("R9 hold untouched", v, 32'h0);
        rd_reg(6'h10, v); check("R9 other offset zero", v, 32'h0);
    endtask

    task automatic test_wrap;
        logic [31:0] c, v;
        addr_n = 6'h04; wdata_n = 32'h0; wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_n = 1'b0;
        addr_n = 6'h00;
        #1 c = rdata_n;
        idle(255 - int'(c[7:0]));
        #1 v = rdata_n; check("R1 narrow count at all-ones", v, 32'h0000_00FF);
        idle(1);
        #1 v = rdata_n; check("R1 wrap to zero", v, 32'h0);
        idle(1);
        #1 v = rdata_n; check("R1 continues after wrap", v, 32'h1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_fields();
        test_fraction();
        test_slow();
        test_clear();
        test_fast();
        test_hold();
        test_unmapped();
        test_wrap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule